// File: doc/BRIEF.md
# Byte-Block DMA Channel

This block is one channel of a byte-wide DMA engine. It copies a block of bytes between a memory bus with 24-bit addresses (the A side) and a bank of peripheral registers with 8-bit addresses (the B side). Software sets it up through seven byte registers: a mode byte, a peripheral register number, a three-byte memory address and a two-byte length. It then writes a shared start register in which each bit belongs to one channel.

Once started, the channel reports itself busy. It spends a fixed lead-in time, then a fixed number of cycles per byte. It steps the low 16 bits of the memory address and counts the length down. The mode field picks the pattern of peripheral registers the bytes go to. When the last byte has moved, the channel drops its busy flag by itself. The total number of busy cycles of the last transfer stays readable on a port.

Top module: `byte_dma_channel`

## Requirements
- R1: After reset all seven window registers read 0 and `ch_busy` is 0. Window offsets are: 0 mode byte, 1 peripheral register number, 2/3/4 address low/middle/bank, 5/6 length low/high. Offset 7 reads 0. Every written byte reads back unchanged.
- R2: A write to the start register starts the channel only if bit `CH_ID` (default 0) is 1. `ch_busy` is 1 from the cycle after that write.
- R3: A transfer of N bytes keeps `ch_busy` high for exactly `LEAD_CYC + BYTE_CYC*N` cycles (8 + 8N by default; 0x800 bytes take 0x4008 cycles). `xfer_cycles` then holds that total, and the channel clears `ch_busy` by itself.
- R4: The length register counts down by one per byte and reads 0 after the transfer. A programmed length of 0 means 65536 bytes.
- R5: Only the low 16 address bits step, and they wrap within the bank; the bank byte never changes. Mode byte bit 4 = 0 steps +1 per byte, bit 4 = 1 steps -1, and bit 3 = 1 holds the address fixed. After a transfer the address reads as the start address plus the step times N.
- R6: Mode bits 2:0 pick the peripheral register offset added to register P for byte k: mode 1 and 5 use k mod 2; mode 3 and 7 use (k/2) mod 2; mode 4 uses k mod 4; modes 0, 2 and 6 always use 0. Register P itself keeps its value after the transfer.
- R7: Mode byte bit 7 = 0 (memory to peripheral): each byte is one cycle with `a_rd` and `b_wr` both high and `b_wdata` = `a_rdata`. Bit 7 = 1: that cycle has `b_rd` and `a_wr` high instead and `a_wdata` = `b_rdata`. The other strobe pair stays low. Bits 6 and 5 are stored but have no effect.
- R8: While `ch_busy` is 1, writes to the register window and to the start register are ignored.
- R9: Byte k (k from 0) moves in busy cycle `LEAD_CYC + BYTE_CYC*(k+1) - 1`, counting busy cycles from 0. No strobe is high outside a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Window register write strobe |
| reg_addr | input | 3 | Window register offset |
| reg_wdata | input | 8 | Window write data |
| reg_rdata | output | 8 | Window read data (combinational on `reg_addr`) |
| go_wr | input | 1 | Start register write strobe |
| go_wdata | input | 8 | Start register data, one bit per channel |
| ch_busy | output | 1 | Channel enabled and transferring |
| xfer_cycles | output | 20 | Busy cycles of the current or last transfer |
| a_addr | output | 24 | Memory-side address |
| a_rd | output | 1 | Memory read strobe |
| a_rdata | input | 8 | Memory read data, same cycle |
| a_wr | output | 1 | Memory write strobe |
| a_wdata | output | 8 | Memory write data |
| b_addr | output | 8 | Peripheral register address |
| b_rd | output | 1 | Peripheral read strobe |
| b_rdata | input | 8 | Peripheral read data, same cycle |
| b_wr | output | 1 | Peripheral write strobe |
| b_wdata | output | 8 | Peripheral write data |

## Verification
The bench sweeps all eight mode values with a length that is not a multiple of four, so each peripheral-offset pattern shows a different sequence. It also runs increasing, decreasing and fixed address steps, including a start near the top of the bank, which shows that the carry is not passed into the bank byte. Lengths from 1 upward and a 0x800-byte block check the cycle formula and the timing of every strobe. A reverse-direction run tells the two strobe pairs apart. Writes made while the channel is busy, a start bit for a different channel, and a zero length (watched for its first bytes) cover the remaining corners.

// File: rtl/byte_dma_pkg.sv
// Package: shared types and constants for the byte-block DMA channel.
// Assumes a byte-wide register window of eight offsets.
package byte_dma_pkg;
    localparam int ADDR_W = 24;
    localparam int LO_W   = 16;
    localparam int CNT_W  = 16;
    localparam int BPORT_W = 8;

    localparam logic [2:0] OFS_MODE  = 3'd0;
    localparam logic [2:0] OFS_PORT  = 3'd1;
    localparam logic [2:0] OFS_A_LO  = 3'd2;
    localparam logic [2:0] OFS_A_MID = 3'd3;
    localparam logic [2:0] OFS_A_BNK = 3'd4;
    localparam logic [2:0] OFS_N_LO  = 3'd5;
    localparam logic [2:0] OFS_N_HI  = 3'd6;

    typedef struct packed {
        logic       to_mem;     // bit 7: 1 = peripheral to memory
        logic       rsv6;
        logic       rsv5;
        logic       step_down;  // bit 4
        logic       hold_addr;  // bit 3
        logic [2:0] pattern;    // bits 2:0
    } mode_byte_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_MOVE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dma_win_regs.sv
// Register window: holds the mode byte, peripheral register number,
// memory address and length. Writes are dropped while busy. Each moved
// byte steps the low address half and counts the length down.
// Assumes step only arrives while busy.
module dma_win_regs
    import byte_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               wr,
    input  logic [2:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               step,
    output logic               to_mem,
    output logic [2:0]         pattern,
    output logic [BPORT_W-1:0] port,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               last_byte
);
    mode_byte_t              mode_q;
    logic [BPORT_W-1:0]      port_q;
    logic [LO_W-1:0]         lo_q;
    logic [ADDR_W-LO_W-1:0]  bank_q;
    logic [CNT_W-1:0]        cnt_q;

    // CPU writes when idle; address and length updates on each moved byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            port_q <= '0;
            lo_q   <= '0;
            bank_q <= '0;
            cnt_q  <= '0;
        end else if (wr && !busy) begin
            case (addr)
                OFS_MODE:  mode_q      <= mode_byte_t'(wdata);
                OFS_PORT:  port_q      <= wdata;
                OFS_A_LO:  lo_q[7:0]   <= wdata;
                OFS_A_MID: lo_q[15:8]  <= wdata;
                OFS_A_BNK: bank_q      <= wdata;
                OFS_N_LO:  cnt_q[7:0]  <= wdata;
                OFS_N_HI:  cnt_q[15:8] <= wdata;
                default: ;
            endcase
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (!mode_q.hold_addr)
                lo_q <= mode_q.step_down ? lo_q - LO_W'(1) : lo_q + LO_W'(1);
        end
    end

    // Read mux for the window
    always_comb begin
        case (addr)
            OFS_MODE:  rdata = mode_q;
            OFS_PORT:  rdata = port_q;
            OFS_A_LO:  rdata = lo_q[7:0];
            OFS_A_MID: rdata = lo_q[15:8];
            OFS_A_BNK: rdata = bank_q;
            OFS_N_LO:  rdata = cnt_q[7:0];
            OFS_N_HI:  rdata = cnt_q[15:8];
            default:   rdata = 8'h00;
        endcase
    end

    assign to_mem    = mode_q.to_mem;
    assign pattern   = mode_q.pattern;
    assign port      = port_q;
    assign mem_addr  = {bank_q, lo_q};
    assign last_byte = (cnt_q == CNT_W'(1));

    // Length falls by exactly one per moved byte
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt_q == $past(cnt_q) - CNT_W'(1));
    // Bank byte untouched by stepping
    assert_bank_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(bank_q));
    // Window frozen while busy
    assert_port_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(port_q) && $stable(mode_q));
endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: lead-in phase, then one byte per BYTE_CYC cycles
// with the move in the slot's last cycle. Counts busy cycles.
// Assumes last_byte reflects the length before the current move.
module dma_seq
    import byte_dma_pkg::*;
#(
    parameter int CH_ID    = 0,
    parameter int LEAD_CYC = 8,
    parameter int BYTE_CYC = 8,
    parameter int CYC_W    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_wr,
    input  logic [7:0]       go_wdata,
    input  logic             last_byte,
    output logic             start,
    output logic             busy,
    output logic             move,
    output logic [CYC_W-1:0] xfer_cycles
);
    localparam int MAXC  = (LEAD_CYC > BYTE_CYC) ? LEAD_CYC : BYTE_CYC;
    localparam int SUB_W = $clog2(MAXC + 1);
    localparam logic [7:0] CH_MASK = 8'(1) << CH_ID;

    seq_state_t       state_q;
    logic [SUB_W-1:0] sub_q;

    assign busy  = (state_q != SEQ_IDLE);
    assign start = go_wr && (|(go_wdata & CH_MASK)) && !busy;
    assign move  = (state_q == SEQ_MOVE) && (sub_q == SUB_W'(BYTE_CYC - 1));

    // Phase and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            sub_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q <= SEQ_LEAD;
                    sub_q   <= '0;
                end
                SEQ_LEAD: if (sub_q == SUB_W'(LEAD_CYC - 1)) begin
                    state_q <= SEQ_MOVE;
                    sub_q   <= '0;
                end else begin
                    sub_q <= sub_q + SUB_W'(1);
                end
                SEQ_MOVE: if (move) begin
                    sub_q <= '0;
                    if (last_byte) state_q <= SEQ_IDLE;
                end else begin
                    sub_q <= sub_q + SUB_W'(1);
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Busy-cycle counter, cleared on start
    always_ff @(posedge clk) begin
        if (!rst_n)     xfer_cycles <= '0;
        else if (start) xfer_cycles <= '0;
        else if (busy)  xfer_cycles <= xfer_cycles + CYC_W'(1);
    end

    // Moves only inside a busy period
    assert_move_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        move |-> busy);
    // Busy ends only right after a move
    assert_end_after_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(move));
    // A start written while busy does not restart the counter
    assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_wr && !move) |=> busy && xfer_cycles == $past(xfer_cycles) + CYC_W'(1));
endmodule

// File: rtl/dma_bport_pat.sv
// Peripheral address pattern: adds a mode-dependent offset to the
// programmed register number, driven by a byte index that restarts
// at each transfer start.
module dma_bport_pat
    import byte_dma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               move,
    input  logic [2:0]         pattern,
    input  logic [BPORT_W-1:0] port,
    output logic [BPORT_W-1:0] b_addr
);
    logic [1:0] idx_q;
    logic [1:0] ofs;

    // Byte index within the four-byte pattern
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= '0;
        else if (start) idx_q <= '0;
        else if (move)  idx_q <= idx_q + 2'd1;
    end

    // Offset selection per pattern
    always_comb begin
        case (pattern)
            3'd1, 3'd5: ofs = {1'b0, idx_q[0]};
            3'd3, 3'd7: ofs = {1'b0, idx_q[1]};
            3'd4:       ofs = idx_q;
            default:    ofs = 2'd0;
        endcase
    end

    assign b_addr = port + BPORT_W'(ofs);

    // Alternating pattern: consecutive moves hit different registers
    assert_alt_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (move && pattern == 3'd1 && !start) |=> (b_addr != $past(b_addr)) || start || $changed(port));
endmodule

// File: rtl/byte_dma_channel.sv
// Top: one DMA channel with register window, start decode, sequencer
// and peripheral pattern. Memory and peripheral data return in the
// same cycle as the read strobe.
module byte_dma_channel
    import byte_dma_pkg::*;
#(
    parameter int CH_ID    = 0,
    parameter int LEAD_CYC = 8,
    parameter int BYTE_CYC = 8,
    parameter int CYC_W    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             go_wr,
    input  logic [7:0]       go_wdata,
    output logic             ch_busy,
    output logic [CYC_W-1:0] xfer_cycles,
    output logic [23:0]      a_addr,
    output logic             a_rd,
    input  logic [7:0]       a_rdata,
    output logic             a_wr,
    output logic [7:0]       a_wdata,
    output logic [7:0]       b_addr,
    output logic             b_rd,
    input  logic [7:0]       b_rdata,
    output logic             b_wr,
    output logic [7:0]       b_wdata
);
    logic               busy, move, start, last_byte, to_mem;
    logic [2:0]         pattern;
    logic [BPORT_W-1:0] port;

    dma_win_regs u_regs (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .step(move), .to_mem(to_mem), .pattern(pattern), .port(port),
        .mem_addr(a_addr), .last_byte(last_byte)
    );

    dma_seq #(
        .CH_ID(CH_ID), .LEAD_CYC(LEAD_CYC), .BYTE_CYC(BYTE_CYC), .CYC_W(CYC_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_wdata(go_wdata),
        .last_byte(last_byte), .start(start), .busy(busy), .move(move),
        .xfer_cycles(xfer_cycles)
    );

    dma_bport_pat u_pat (
        .clk(clk), .rst_n(rst_n), .start(start), .move(move),
        .pattern(pattern), .port(port), .b_addr(b_addr)
    );

    assign ch_busy = busy;
    assign a_rd    = move && !to_mem;
    assign b_wr    = move && !to_mem;
    assign b_wdata = a_rdata;
    assign b_rd    = move && to_mem;
    assign a_wr    = move && to_mem;
    assign a_wdata = b_rdata;

    // Only one direction's strobe pair per cycle
    assert_one_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_rd, b_rd}) && $onehot0({a_wr, b_wr}));
    // Memory read pairs with a peripheral write
    assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd |-> b_wr && !a_wr);
    // No strobe when idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_busy |-> !(a_rd || a_wr || b_rd || b_wr));
endmodule

// File: tb/byte_dma_channel_tb.sv
`timescale 1ns/1ps
module byte_dma_channel_tb;
    localparam int LEAD = 8;
    localparam int BYTE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic go_wr = 1'b0;
    logic [7:0] go_wdata = '0;
    logic ch_busy;
    logic [19:0] xfer_cycles;
    logic [23:0] a_addr;
    logic a_rd, a_wr, b_rd, b_wr;
    logic [7:0] a_rdata, a_wdata, b_addr, b_rdata, b_wdata;

    always #2 clk = ~clk;

    byte_dma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .go_wr(go_wr),
        .go_wdata(go_wdata), .ch_busy(ch_busy), .xfer_cycles(xfer_cycles),
        .a_addr(a_addr), .a_rd(a_rd), .a_rdata(a_rdata), .a_wr(a_wr),
        .a_wdata(a_wdata), .b_addr(b_addr), .b_rd(b_rd), .b_rdata(b_rdata),
        .b_wr(b_wr), .b_wdata(b_wdata)
    );

    function automatic logic [7:0] mem_val(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] per_val(input logic [7:0] b);
        return ~b ^ 8'h33;
    endfunction
    function automatic int pat_ofs(input int mode, input int k);
        if (mode == 1 || mode == 5) return k % 2;
        if (mode == 3 || mode == 7) return (k / 2) % 2;
        if (mode == 4) return k % 4;
        return 0;
    endfunction

    assign a_rdata = mem_val(a_addr);
    assign b_rdata = per_val(b_addr);

    int n_cmp = 0;
    int n_bad = 0;
    int wd = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expectations for the monitor
    int exp_mode = 0, exp_step = 1, mon_cyc = 0, mon_k = 0;
    logic [7:0]  exp_port = '0, exp_bank = '0;
    logic [15:0] exp_lo = '0;
    logic        exp_dir = 1'b0;

    // Per-cycle monitor of the strobes during a transfer
    always @(negedge clk) begin
        if (rst_n && !ch_busy)
            chk("R9 idle strobes", {a_rd, a_wr, b_rd, b_wr}, 4'b0);
        if (rst_n && ch_busy) begin
            if (a_rd || a_wr || b_rd || b_wr) begin
                logic [23:0] ea;
                logic [7:0]  eb;
                ea = {exp_bank, 16'(int'(exp_lo) + exp_step * mon_k)};
                eb = 8'(int'(exp_port) + pat_ofs(exp_mode, mon_k));
                chk("R9 move cycle", mon_cyc, LEAD + BYTE * (mon_k + 1) - 1);
                chk("R5 a_addr", a_addr, ea);
                chk("R6 b_addr", b_addr, eb);
                if (!exp_dir) begin
                    chk("R7 strobes A->B", {a_rd, a_wr, b_rd, b_wr}, 4'b1001);
                    chk("R7 b_wdata", b_wdata, mem_val(ea));
                end else begin
                    chk("R7 strobes B->A", {a_rd, a_wr, b_rd, b_wr}, 4'b0110);
                    chk("R7 a_wdata", a_wdata, per_val(eb));
                end
                mon_k++;
            end
            mon_cyc++;
        end
    end

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask
    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask
    task automatic go(input logic [7:0] d);
        @(negedge clk); go_wr = 1'b1; go_wdata = d;
        @(negedge clk); go_wr = 1'b0;
    endtask

    task automatic setup(input logic [7:0] ctl, input logic [7:0] port,
                         input logic [23:0] a, input logic [15:0] n);
        wreg(3'd0, ctl); wreg(3'd1, port);
        wreg(3'd2, a[7:0]); wreg(3'd3, a[15:8]); wreg(3'd4, a[23:16]);
        wreg(3'd5, n[7:0]); wreg(3'd6, n[15:8]);
        exp_mode = int'(ctl[2:0]); exp_port = port; exp_bank = a[23:16];
        exp_lo = a[15:0]; exp_dir = ctl[7];
        exp_step = ctl[3] ? 0 : (ctl[4] ? -1 : 1);
        mon_cyc = 0; mon_k = 0;
    endtask

    task automatic finish_checks(input logic [7:0] ctl, input logic [7:0] port, input int n);
        logic [7:0] v0, v1, v2;
        logic [15:0] elo;
        elo = 16'(int'(exp_lo) + exp_step * n);
        chk("R3 busy cycles", mon_cyc, LEAD + BYTE * n);
        chk("R3 xfer_cycles", xfer_cycles, LEAD + BYTE * n);
        chk("R4 bytes moved", mon_k, n);
        rreg(3'd5, v0); rreg(3'd6, v1);
        chk("R4 length zero", {v1, v0}, 16'h0);
        rreg(3'd2, v0); rreg(3'd3, v1); rreg(3'd4, v2);
        chk("R5 end address", {v2, v1, v0}, {exp_bank, elo});
        rreg(3'd1, v0);
        chk("R6 port kept", v0, port);
        rreg(3'd0, v0);
        chk("R1 mode byte kept", v0, ctl);
    endtask

    task automatic run(input logic [7:0] ctl, input logic [7:0] port,
                       input logic [23:0] a, input logic [15:0] n);
        setup(ctl, port, a, n);
        go(8'h01);
        chk("R2 busy after start", ch_busy, 1'b1);
        while (ch_busy) @(negedge clk);
        finish_checks(ctl, port, int'(n));
    endtask

    // Watchdog
    always @(posedge clk) begin
        wd++;
        if (wd == 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy after reset", ch_busy, 1'b0);
        for (int i = 0; i < 8; i++) begin
            rreg(3'(i), v);
            chk("R1 reset read", v, 8'h00);
        end
        // R1 readback of every offset
        for (int i = 0; i < 7; i++) wreg(3'(i), 8'(8'hA1 + 8'(i * 17)));
        for (int i = 0; i < 7; i++) begin
            rreg(3'(i), v);
            chk("R1 readback", v, 8'(8'hA1 + 8'(i * 17)));
        end
        wreg(3'd7, 8'hEE);
        rreg(3'd7, v);
        chk("R1 offset 7", v, 8'h00);
        // R2 start bit of another channel does nothing
        setup(8'h00, 8'h10, 24'h010000, 16'd2);
        go(8'hFE);
        repeat (3) @(negedge clk);
        chk("R2 other channel bit", ch_busy, 1'b0);
        // R6 sweep of all patterns, odd length
        for (int m = 0; m < 8; m++)
            run(8'(m), 8'h18, 24'h7E0100, 16'd7);
        // R3 lengths 1..6
        for (int n = 1; n <= 6; n++)
            run(8'h01, 8'h40, 24'h020010, 16'(n));
        // R5 decrement, fixed, wrap within bank (bits 6,5 set: no effect, R7)
        run(8'h10, 8'h22, 24'h030005, 16'd9);
        run(8'h08, 8'h22, 24'h030005, 16'd5);
        run(8'h60, 8'h22, 24'h12FFFE, 16'd4);
        run(8'h10, 8'h22, 24'h120001, 16'd3);
        // R7 reverse direction
        run(8'h81, 8'hFF, 24'h05ABCD, 16'd6);
        // R3 large block 0x800 bytes: 0x4008 cycles
        run(8'h01, 8'h18, 24'h7E0000, 16'h0800);
        // R8 writes while busy are ignored
        setup(8'h01, 8'h30, 24'h040000, 16'd4);
        go(8'h01);
        while (mon_k < 1) @(negedge clk);
        wreg(3'd1, 8'h77);
        wreg(3'd0, 8'h04);
        go(8'hFF);
        while (ch_busy) @(negedge clk);
        finish_checks(8'h01, 8'h30, 4);
        // R4 length 0 means 65536 bytes: watch the first bytes
        setup(8'h00, 8'h50, 24'h060000, 16'h0000);
        go(8'h01);
        while (mon_k < 3) @(negedge clk);
        begin
            logic [7:0] lo, hi;
            rreg(3'd5, lo); rreg(3'd6, hi);
            chk("R4 zero length counts down", {hi, lo}, 16'hFFFD);
            chk("R4 zero length still busy", ch_busy, 1'b1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule